// File: doc/BRIEF.md
# Stepped Frequency Sweep Phase Generator

This block drives a stepped frequency sweep for an impedance measurement path. A phase accumulator adds a frequency tuning word to its phase every clock. The phase goes to a sine lookup and to the correlation (DFT) stage. Before a sweep, a host places three values on the programming inputs: a start word, a per-step delta word and a step limit. It then issues commands on a 4-bit command input.

An initialize command loads the start word and clears the step counter. It also captures the delta and the limit and starts the accumulator, but it does not request a measurement. A start command requests the first measurement. After each measurement reports done, the block waits for the host to either increment the frequency or repeat the current point. Each of these requests a fresh measurement.

When the measurement at the final step reports done, the block raises a sweep-complete flag. The flag stays set until the next initialize. The accumulator is never cleared by a step or a re-initialize, so the excitation phase stays continuous.

The controller has five states:
- IDLE: after reset; the accumulator is stopped.
- ARMED: after initialize; waiting for start.
- MEASURE: a measurement is in flight.
- HOLD: the point is done and the block waits for increment or repeat.
- COMPLETE: the sweep is finished.

The transitions are:
- init: any state goes to ARMED.
- start: ARMED goes to MEASURE.
- point_done: MEASURE goes to HOLD when the counter is below the limit.
- last_done: MEASURE goes to COMPLETE when the counter equals the limit.
- step: HOLD goes to MEASURE with the frequency advanced.
- again: HOLD goes to MEASURE with the frequency unchanged.

Top module: `sweep_dds_ctrl`

## Requirements
- R1: After reset, phase, frequency word and step index are zero, and the measure-start, busy, sweep-complete and accumulator-on outputs are low.
- R2: In IDLE the phase does not change, and commands other than initialize (code 1) have no effect. This includes start (code 2) and any code above 4.
- R3: Initialize (code 1), accepted in any state, makes the frequency word equal the start word and the step index zero on the next cycle. It clears sweep-complete, raises accumulator-on and issues no measure-start. Initialize takes priority over measurement-done in the same cycle.
- R4: While accumulator-on is high, the phase after each clock equals the previous phase plus the previous frequency word, modulo 2^FW. The phase is never reset by a step, a repeat or a re-initialize.
- R5: Start (code 2) in ARMED gives a measure-start pulse exactly one cycle wide on the next cycle. Busy stays high from then on until measurement-done is seen.
- R6: Measurement-done in MEASURE, with the step index below the captured limit, drops busy on the next cycle and moves to HOLD. While busy, every command except initialize is ignored.
- R7: Increment (code 3) in HOLD adds the delta word captured at initialize to the frequency word (modulo 2^FW), adds one to the step index and pulses measure-start.
- R8: Repeat (code 4) in HOLD pulses measure-start and leaves the frequency word and step index unchanged.
- R9: Measurement-done while the step index equals the captured limit sets sweep-complete. It stays set until the next initialize. Increment and repeat have no effect once complete.
- R10: With a captured limit of zero, the first measurement after start completes the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Accumulator and control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 4 | Command: 0 none, 1 initialize, 2 start, 3 increment, 4 repeat |
| start_word | input | FW | Start tuning word, loaded on initialize |
| delta_word | input | FW | Per-step increment, captured on initialize |
| step_limit | input | CW | Number of increments, captured on initialize |
| meas_done | input | 1 | Measurement finished for the current point |
| phase | output | FW | Accumulated phase |
| freq_word | output | FW | Current tuning word |
| step_idx | output | CW | Increments taken since initialize |
| meas_start | output | 1 | One-cycle request to start a measurement |
| busy | output | 1 | A measurement is in flight |
| sweep_done | output | 1 | Sweep complete |
| acc_on | output | 1 | Accumulator running |

## Verification
The bench keeps the full 27-bit tuning width. It uses a start word near half of full scale, so the phase wraps within a few cycles and the modulo arithmetic is exercised. The step counter width is reduced to 4 bits. This lets the largest limit, 15, be swept to the end and then pushed past with a further increment. A zero limit and a re-initialize in the middle of a sweep also fit in a short run.

// File: rtl/sweep_dds_pkg.sv
package sweep_dds_pkg;
    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_INIT   = 4'd1,
        CMD_START  = 4'd2,
        CMD_INC    = 4'd3,
        CMD_REPEAT = 4'd4
    } sweep_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_MEASURE,
        ST_HOLD,
        ST_COMPLETE
    } sweep_state_e;
endpackage

// File: rtl/sweep_ctrl_fsm.sv
module sweep_ctrl_fsm
    import sweep_dds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cmd,
    input  logic       meas_done,
    input  logic       at_limit,
    output logic       ld_init,
    output logic       step_en,
    output logic       meas_start,
    output logic       busy,
    output logic       complete,
    output logic       acc_on
);
    sweep_state_e state_q, state_d;
    logic         go_meas;

    // next-state and command strobes
    always_comb begin
        state_d = state_q;
        ld_init = 1'b0;
        step_en = 1'b0;
        go_meas = 1'b0;
        if (cmd == CMD_INIT) begin
            ld_init = 1'b1;
            state_d = ST_ARMED;                          // init
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ARMED: begin
                    if (cmd == CMD_START) begin          // start
                        go_meas = 1'b1;
                        state_d = ST_MEASURE;
                    end
                end
                ST_MEASURE: begin
                    if (meas_done)                       // point_done / last_done
                        state_d = at_limit ? ST_COMPLETE : ST_HOLD;
                end
                ST_HOLD: begin
                    if (cmd == CMD_INC && !at_limit) begin   // step
                        step_en = 1'b1;
                        go_meas = 1'b1;
                        state_d = ST_MEASURE;
                    end else if (cmd == CMD_REPEAT) begin    // again
                        go_meas = 1'b1;
                        state_d = ST_MEASURE;
                    end
                end
                ST_COMPLETE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            meas_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            meas_start <= go_meas;
        end
    end

    // state-decoded outputs
    always_comb begin
        busy     = (state_q == ST_MEASURE);
        complete = (state_q == ST_COMPLETE);
        acc_on   = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sweep_freq_reg.sv
module sweep_freq_reg #(
    parameter int FW = 27,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_init,
    input  logic          step_en,
    input  logic [FW-1:0] start_word,
    input  logic [FW-1:0] delta_word,
    input  logic [CW-1:0] step_limit,
    output logic [FW-1:0] freq_word,
    output logic [CW-1:0] step_idx,
    output logic          at_limit
);
    logic [FW-1:0] delta_q;
    logic [CW-1:0] limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_word <= '0;
            step_idx  <= '0;
            delta_q   <= '0;
            limit_q   <= '0;
        end else if (ld_init) begin
            freq_word <= start_word;
            step_idx  <= '0;
            delta_q   <= delta_word;
            limit_q   <= step_limit;
        end else if (step_en) begin
            freq_word <= freq_word + delta_q;
            step_idx  <= step_idx + 1'b1;
        end
    end

    assign at_limit = (step_idx == limit_q);
endmodule

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
    parameter int FW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] freq_word,
    output logic [FW-1:0] phase
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (run)
            phase <= phase + freq_word;
    end
endmodule

// File: rtl/sweep_dds_ctrl.sv
module sweep_dds_ctrl #(
    parameter int FW = 27,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cmd,
    input  logic [FW-1:0] start_word,
    input  logic [FW-1:0] delta_word,
    input  logic [CW-1:0] step_limit,
    input  logic          meas_done,
    output logic [FW-1:0] phase,
    output logic [FW-1:0] freq_word,
    output logic [CW-1:0] step_idx,
    output logic          meas_start,
    output logic          busy,
    output logic          sweep_done,
    output logic          acc_on
);
    logic ld_init, step_en, at_limit;

    sweep_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .meas_done  (meas_done),
        .at_limit   (at_limit),
        .ld_init    (ld_init),
        .step_en    (step_en),
        .meas_start (meas_start),
        .busy       (busy),
        .complete   (sweep_done),
        .acc_on     (acc_on)
    );

    sweep_freq_reg #(.FW(FW), .CW(CW)) u_freq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_init    (ld_init),
        .step_en    (step_en),
        .start_word (start_word),
        .delta_word (delta_word),
        .step_limit (step_limit),
        .freq_word  (freq_word),
        .step_idx   (step_idx),
        .at_limit   (at_limit)
    );

    sweep_phase_acc #(.FW(FW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (acc_on),
        .freq_word (freq_word),
        .phase     (phase)
    );
endmodule

// File: rtl/sweep_dds_checker.sv
module sweep_dds_checker
    import sweep_dds_pkg::*;
#(
    parameter int FW = 27,
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cmd,
    input logic [FW-1:0] start_word,
    input logic          meas_done,
    input logic [FW-1:0] phase,
    input logic [FW-1:0] freq_word,
    input logic [CW-1:0] step_idx,
    input logic          meas_start,
    input logic          busy,
    input logic          sweep_done,
    input logic          acc_on
);
    assert_idle_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_on |=> $stable(phase));

    assert_init_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INIT) |=> (freq_word == $past(start_word)) && (step_idx == '0)
                              && !sweep_done && !meas_start && acc_on);

    assert_phase_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_on |=> (phase == FW'($past(phase) + $past(freq_word))));

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |=> !meas_start);

    assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && meas_done && cmd != CMD_INIT) |=> !busy);

    assert_freq_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd != CMD_INIT) |=> $stable(freq_word) && $stable(step_idx));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done && cmd != CMD_INIT) |=> sweep_done && !meas_start);
endmodule

bind sweep_dds_ctrl sweep_dds_checker #(.FW(FW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .start_word (start_word),
    .meas_done  (meas_done),
    .phase      (phase),
    .freq_word  (freq_word),
    .step_idx   (step_idx),
    .meas_start (meas_start),
    .busy       (busy),
    .sweep_done (sweep_done),
    .acc_on     (acc_on)
);

// File: tb/test_sweep_dds_ctrl.sv
module test_sweep_dds_ctrl;
    localparam int FW = 27;
    localparam int CW = 4;
    localparam int EW = 2*FW + CW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cmd = 4'd0;
    logic [FW-1:0] start_word = '0;
    logic [FW-1:0] delta_word = '0;
    logic [CW-1:0] step_limit = '0;
    logic          meas_done = 1'b0;
    logic [FW-1:0] phase, freq_word;
    logic [CW-1:0] step_idx;
    logic          meas_start, busy, sweep_done, acc_on;

    always #4 clk = ~clk;

    sweep_dds_ctrl #(.FW(FW), .CW(CW)) i_sweep_dds_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_word(start_word),
        .delta_word(delta_word), .step_limit(step_limit), .meas_done(meas_done),
        .phase(phase), .freq_word(freq_word), .step_idx(step_idx),
        .meas_start(meas_start), .busy(busy), .sweep_done(sweep_done), .acc_on(acc_on)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    // reference model: 0 idle, 1 armed, 2 measure, 3 hold, 4 complete
    int            m_st = 0;
    logic [FW-1:0] m_ph = '0, m_fw = '0, m_delta = '0;
    logic [CW-1:0] m_step = '0, m_lim = '0;

    task automatic cyc(input logic [3:0] c, input logic d, input string tag);
        logic [FW-1:0] nph;
        logic          nms;
        cmd = c;
        meas_done = d;
        nph = (m_st != 0) ? m_ph + m_fw : m_ph;
        nms = 1'b0;
        if (c == 4'd1) begin
            m_fw = start_word; m_step = '0; m_delta = delta_word; m_lim = step_limit; m_st = 1;
        end else begin
            case (m_st)
                1: if (c == 4'd2) begin m_st = 2; nms = 1'b1; end
                2: if (d) m_st = (m_step == m_lim) ? 4 : 3;
                3: if (c == 4'd3) begin
                       m_fw = m_fw + m_delta; m_step = m_step + 1'b1; m_st = 2; nms = 1'b1;
                   end else if (c == 4'd4) begin
                       m_st = 2; nms = 1'b1;
                   end
                default: ;
            endcase
        end
        m_ph = nph;
        @(posedge clk);
        exp_q.push_back({m_ph, m_fw, m_step, nms, (m_st == 2), (m_st == 4), (m_st != 0)});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [EW-1:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {phase, freq_word, step_idx, meas_start, busy, sweep_done, acc_on};
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if ({phase, freq_word, step_idx, meas_start, busy, sweep_done, acc_on} !== '0) begin
            n_fail++;
            $display("FAIL R1: actual %h expected 0",
                     {phase, freq_word, step_idx, meas_start, busy, sweep_done, acc_on});
        end
        rst_n = 1'b1;
        cyc(4'd0, 1'b0, "R1");
        cyc(4'd2, 1'b0, "R2");           // start ignored while idle
        cyc(4'd9, 1'b0, "R2");           // undefined code
        cyc(4'd3, 1'b1, "R2");

        start_word = 27'h400_0123;       // near half scale: phase wraps quickly
        delta_word = 27'h000_0451;
        step_limit = 4'd2;
        cyc(4'd1, 1'b0, "R3");
        repeat (3) cyc(4'd0, 1'b0, "R4");
        cyc(4'd2, 1'b0, "R5");
        cyc(4'd3, 1'b0, "R6");           // increment ignored while busy
        cyc(4'd4, 1'b0, "R6");
        cyc(4'd0, 1'b1, "R6");
        cyc(4'd0, 1'b0, "R6");
        cyc(4'd3, 1'b0, "R7");
        cyc(4'd0, 1'b1, "R6");
        cyc(4'd4, 1'b0, "R8");
        cyc(4'd0, 1'b0, "R8");
        cyc(4'd0, 1'b1, "R8");
        cyc(4'd3, 1'b0, "R7");
        cyc(4'd0, 1'b1, "R9");           // last point done
        cyc(4'd3, 1'b0, "R9");           // ignored once complete
        cyc(4'd4, 1'b0, "R9");
        cyc(4'd2, 1'b1, "R9");

        // re-initialize mid-sweep, init wins over done
        step_limit = 4'd0;
        start_word = 27'h000_7777;
        cyc(4'd1, 1'b0, "R3");
        cyc(4'd2, 1'b0, "R10");
        cyc(4'd1, 1'b1, "R3");
        cyc(4'd2, 1'b0, "R10");
        cyc(4'd0, 1'b1, "R10");
        cyc(4'd0, 1'b0, "R10");

        // full-length sweep to the largest limit
        step_limit = 4'd15;
        delta_word = 27'h7FF_FFF0;       // increment wraps the tuning word
        cyc(4'd1, 1'b0, "R3");
        cyc(4'd2, 1'b0, "R5");
        cyc(4'd0, 1'b1, "R6");
        for (int i = 0; i < 15; i++) begin
            cyc(4'd3, 1'b0, "R7");
            cyc(4'd0, 1'b1, "R9");
        end
        cyc(4'd3, 1'b0, "R9");
        cyc(4'd0, 1'b0, "R4");

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule